// File: doc/BRIEF.md
# Oscillator Fail Flag Logic

This block holds the sticky "clock data may be invalid" flag of a real-time clock, together with the two control bits that sit beside it: the oscillator stop bit and the general-purpose output bit. It runs on a fast system clock that is independent of the 32.768 kHz timekeeping oscillator. It samples that oscillator through a synchronizer and declares the oscillator lost when no edge arrives within a programmable number of system clocks.

The flag is raised by reset, by a supply-low input, by the stop bit, and by loss of oscillation. After that it stays raised until software clears it. A clear is honoured only after the oscillator has run without interruption for a set number of its own cycles. With the defaults this is 131072 cycles, which is four seconds at 32.768 kHz. Any stop condition restarts that run count from zero.

Register writes arrive as a one-cycle strobe with a 3-bit address and an 8-bit data byte. Only bit 7 at three addresses is stored here. The output bit drives an open-drain pin enable. The stop bit also produces the enable signal for the analog oscillator.

Top module: `osc_fail_ctrl`

## Requirements
- R1: After reset, `fail_flag` is 1, `stop_bit` is 0, `osc_run_en` is 1, and the output bit is 1, so `out_drive_low` is 0.
- R2: A cycle in which `supply_low` is 1 sets `fail_flag` to 1 at the next clock edge.
- R3: A write to address 0 loads data bit 7 into `stop_bit` at the next edge. `osc_run_en` is the inverse of `stop_bit`. While `stop_bit` is 1, `fail_flag` is set at every edge.
- R4: When the synchronized oscillator shows no edge for `TIMEOUT_CLKS` system clocks, the oscillator counts as lost and `fail_flag` is set. An oscillator toggling faster than that never sets the flag.
- R5: `fail_flag` stays 1 until an accepted clear. A clear is a write to address 1 with data bit 7 equal to 0.
- R6: A clear is ignored, and the flag stays 1, unless `RUN_CYCLES` rising oscillator edges have been counted since the last stop condition. A stop condition is supply low, the stop bit, or a lost oscillator. Each stop condition restarts the count at zero. A stop condition present in the same cycle as a clear wins.
- R7: A write to address 1 with data bit 7 equal to 1 sets `fail_flag`.
- R8: A write to address 7 loads data bit 7 into the output bit. `out_drive_low` is 1 exactly when that bit is 0.
- R9: Writes to addresses other than 0, 1 and 7 do not change any of the three bits. Data bits 6 to 0 are ignored at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the oscillator |
| rst_n | input | 1 | Active-low power-on reset |
| osc_in | input | 1 | Raw 32.768 kHz oscillator, asynchronous to clk |
| supply_low | input | 1 | Supply too low to sustain oscillation |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data byte; only bit 7 is used |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| stop_bit | output | 1 | Stored oscillator stop request |
| osc_run_en | output | 1 | Enable for the analog oscillator |
| out_drive_low | output | 1 | Open-drain enable: 1 pulls the output pin low |

## Verification
The bench tries to clear the flag too early in three cases: right after reset, right after a supply-low pulse, and while the stop bit holds the oscillator off. A design that ignored the run-time gate, or that did not restart the run count on a stop condition, would drop the flag in those cases. The bench also silences the oscillator for longer than the timeout to confirm that the flag is raised. It runs the oscillator normally for long stretches to confirm that a healthy oscillator never trips the detector. Writes to unused addresses, and writes with only the low data bits set, check that decoding depends on the address and on bit 7 alone.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;
  localparam logic [2:0] ADDR_STOP = 3'd0;
  localparam logic [2:0] ADDR_FLAG = 3'd1;
  localparam logic [2:0] ADDR_OUT  = 3'd7;
  localparam int         KEY_BIT   = 7;

  // Next value of the sticky flag, in priority order:
  // stop condition, software set, gated software clear, hold.
  function automatic logic flag_next(input logic cur, input logic stop_ev,
                                     input logic set_req, input logic clr_req,
                                     input logic run_ok);
    if (stop_ev)              return 1'b1;
    if (set_req)              return 1'b1;
    if (clr_req && run_ok)    return 1'b0;
    return cur;
  endfunction

  // Saturating increment toward a limit.
  function automatic int unsigned sat_inc(input int unsigned cnt, input int unsigned lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction
endpackage

// File: rtl/ofl_sync.sv
module ofl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ofl_edge_watch.sv
module ofl_edge_watch #(
  parameter int TIMEOUT_CLKS = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_s,
  output logic rise,
  output logic lost
);
  import osc_fail_pkg::*;
  localparam int CW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CLKS);

  logic          prev_q;
  logic          any_edge;
  logic [CW-1:0] quiet_q;

  assign any_edge = osc_s ^ prev_q;
  assign rise     = osc_s & ~prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= osc_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        quiet_q <= '0;
    else if (any_edge) quiet_q <= '0;
    else               quiet_q <= CW'(sat_inc(int'(quiet_q), TIMEOUT_CLKS));

  assign lost = (quiet_q == LIM);
endmodule

// File: rtl/ofl_run_timer.sv
module ofl_run_timer #(
  parameter int RUN_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic run_ok
);
  import osc_fail_pkg::*;
  localparam int CW = $clog2(RUN_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       run_q <= '0;
    else if (restart) run_q <= '0;
    else if (tick)    run_q <= CW'(sat_inc(int'(run_q), RUN_CYCLES));

  assign run_ok = (run_q == LIM);
endmodule

// File: rtl/osc_fail_ctrl.sv
module osc_fail_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int TIMEOUT_CLKS = 12288,
  parameter int RUN_CYCLES   = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_in,
  input  logic       supply_low,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       fail_flag,
  output logic       stop_bit,
  output logic       osc_run_en,
  output logic       out_drive_low
);
  import osc_fail_pkg::*;

  logic osc_s, osc_rise, osc_lost, run_ok, stop_event;
  logic wr_stop, wr_flag, wr_out, set_req, clr_req;
  logic stop_q, flag_q, out_q;

  ofl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(osc_in), .q(osc_s));

  ofl_edge_watch #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_watch (
    .clk(clk), .rst_n(rst_n), .osc_s(osc_s), .rise(osc_rise), .lost(osc_lost));

  assign stop_event = stop_q | supply_low | osc_lost;

  ofl_run_timer #(.RUN_CYCLES(RUN_CYCLES)) u_run (
    .clk(clk), .rst_n(rst_n), .restart(stop_event), .tick(osc_rise), .run_ok(run_ok));

  assign wr_stop = wr_en && (wr_addr == ADDR_STOP);
  assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);
  assign wr_out  = wr_en && (wr_addr == ADDR_OUT);
  assign set_req = wr_flag &&  wr_data[KEY_BIT];
  assign clr_req = wr_flag && !wr_data[KEY_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       stop_q <= 1'b0;
    else if (wr_stop) stop_q <= wr_data[KEY_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      out_q <= 1'b1;
    else if (wr_out) out_q <= wr_data[KEY_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_next(flag_q, stop_event, set_req, clr_req, run_ok);

  assign fail_flag     = flag_q;
  assign stop_bit      = stop_q;
  assign osc_run_en    = ~stop_q;
  assign out_drive_low = ~out_q;
endmodule

// File: rtl/osc_fail_chk.sv
module osc_fail_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_low,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       stop_event,
  input logic       osc_lost,
  input logic       run_ok,
  input logic       fail_flag,
  input logic       stop_bit,
  input logic       out_drive_low
);
  p_supply_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> fail_flag);

  p_stop_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (stop_bit == $past(wr_data[7])));

  p_stop_holds_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> fail_flag);

  p_lost_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    osc_lost |=> fail_flag);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !(wr_en && wr_addr == 3'd1 && !wr_data[7])) |=> fail_flag);

  p_clear_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(run_ok));

  p_run_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_event |=> !run_ok);

  p_set_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && wr_data[7]) |=> fail_flag);

  p_out_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |=> (out_drive_low == !$past(wr_data[7])));

  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 3'd0 && wr_addr != 3'd7) |=>
      ($stable(stop_bit) && $stable(out_drive_low)));
endmodule

bind osc_fail_ctrl osc_fail_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .stop_event(stop_event),
  .osc_lost(osc_lost), .run_ok(run_ok), .fail_flag(fail_flag),
  .stop_bit(stop_bit), .out_drive_low(out_drive_low));

// File: tb/osc_fail_ctrl_bench.sv
module osc_fail_ctrl_bench;
  localparam int TMO = 32;
  localparam int RUN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc = 1'b0;
  logic osc_en = 1'b1;
  int   div = 0;
  logic supply_low = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic fail_flag, stop_bit, osc_run_en, out_drive_low;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Oscillator model: period of 10 system clocks, halted by the bench or by the run enable.
  always @(posedge clk)
    if (osc_en && osc_run_en) begin
      if (div == 4) begin div <= 0; osc <= ~osc; end
      else div <= div + 1;
    end

  osc_fail_ctrl #(.SYNC_STAGES(2), .TIMEOUT_CLKS(TMO), .RUN_CYCLES(RUN)) u_osc_fail_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_in(osc), .supply_low(supply_low),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fail_flag(fail_flag), .stop_bit(stop_bit), .osc_run_en(osc_run_en),
    .out_drive_low(out_drive_low));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Vector: kind(2) addr(3) data(8) idle(16) flag stop drive_low req(4)
  // kind 0 = write, 1 = idle only, 2 = supply-low pulse, 3 = set osc_en to data[0]
  localparam int NV = 25;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b1, 1'b0, 1'b0, 4'd6},  // R6 clear right after reset ignored
    {2'd1, 3'd0, 8'h00, 16'd300, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 flag holds with no write
    {2'd0, 3'd1, 8'h7F, 16'd1,   1'b0, 1'b0, 1'b0, 4'd5},  // R5 clear accepted, low bits ignored
    {2'd1, 3'd0, 8'h00, 16'd200, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 running oscillator never trips
    {2'd2, 3'd0, 8'h00, 16'd1,   1'b1, 1'b0, 1'b0, 4'd2},  // R2 supply-low pulse sets flag
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b1, 1'b0, 1'b0, 4'd6},  // R6 run count restarted
    {2'd1, 3'd0, 8'h00, 16'd250, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b0, 1'b0, 1'b0, 4'd5},  // R5 clear after full run
    {2'd0, 3'd3, 8'h00, 16'd1,   1'b0, 1'b0, 1'b0, 4'd9},  // R9 other address
    {2'd0, 3'd1, 8'h80, 16'd1,   1'b1, 1'b0, 1'b0, 4'd7},  // R7 software set
    {2'd1, 3'd0, 8'h00, 16'd250, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b0, 1'b0, 1'b0, 4'd5},  // R5
    {2'd0, 3'd0, 8'h80, 16'd1,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 stop bit sets flag
    {2'd1, 3'd0, 8'h00, 16'd250, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b1, 1'b1, 1'b0, 4'd6},  // R6 clear while stopped ignored
    {2'd0, 3'd0, 8'h00, 16'd1,   1'b1, 1'b0, 1'b0, 4'd3},  // R3 stop released
    {2'd1, 3'd0, 8'h00, 16'd250, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b0, 1'b0, 1'b0, 4'd6},  // R6 clear after restart run
    {2'd3, 3'd0, 8'h00, 16'd80,  1'b1, 1'b0, 1'b0, 4'd4},  // R4 silent oscillator sets flag
    {2'd3, 3'd0, 8'h01, 16'd250, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {2'd0, 3'd1, 8'h00, 16'd1,   1'b0, 1'b0, 1'b0, 4'd4},  // R4 recovery then clear
    {2'd0, 3'd7, 8'h7F, 16'd1,   1'b0, 1'b0, 1'b1, 4'd8},  // R8 output bit 0 pulls low
    {2'd0, 3'd5, 8'h80, 16'd1,   1'b0, 1'b0, 1'b1, 4'd9},  // R9 other address
    {2'd0, 3'd7, 8'h80, 16'd1,   1'b0, 1'b0, 1'b0, 4'd8},  // R8 output released
    {2'd0, 3'd0, 8'h7F, 16'd1,   1'b0, 1'b0, 1'b0, 4'd9}   // R9 low bits do not set stop
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "fail_flag", fail_flag, 1'b1);
    chk("R1", "stop_bit", stop_bit, 1'b0);
    chk("R1", "osc_run_en", osc_run_en, 1'b1);
    chk("R1", "out_drive_low", out_drive_low, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      case (v[35:34])
        2'd0: begin wr_en = 1'b1; wr_addr = v[33:31]; wr_data = v[30:23]; end
        2'd2: supply_low = 1'b1;
        2'd3: osc_en = v[23];
        default: ;
      endcase
      @(negedge clk);
      wr_en = 1'b0; supply_low = 1'b0;
      repeat (int'(v[22:7])) @(negedge clk);
      chk(tag, "fail_flag", fail_flag, v[6]);
      chk(tag, "stop_bit", stop_bit, v[5]);
      chk(tag, "out_drive_low", out_drive_low, v[4]);
    end

    // R3 run enable follows the stop bit
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    chk("R3", "osc_run_en while stopped", osc_run_en, 1'b0);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    chk("R3", "osc_run_en after release", osc_run_en, 1'b1);

    // R1 reset restores defaults after the bits were changed
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h00;
    @(negedge clk);
    wr_addr = 3'd0; wr_data = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    chk("R8", "out_drive_low before reset", out_drive_low, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "fail_flag after reset", fail_flag, 1'b1);
    chk("R1", "stop_bit after reset", stop_bit, 1'b0);
    chk("R1", "out_drive_low after reset", out_drive_low, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule